// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 10-bit successive-approximation converter. A host starts a conversion by pulling the write strobe low while chip select is low. For as long as the strobe stays active, the sequencer holds an initialization phase. In that phase the trial code sits at full scale, the analog front end is told to auto-zero, and the positive input is sampled.

When the strobe is released, the sequencer waits for the next boundary of a free-running divide-by-4 phase counter. It then tests the ten bits from the most significant down, spending four clocks on each. On the last clock of every slot it reads a single-bit comparator input. Because bit testing always starts on a phase boundary, conversions released at intervals that are a multiple of four clocks all take the same time. This keeps sampling intervals equal.

Two clocks after the final decision, the code is copied into a result register. At the same edge a one-cycle end-of-conversion pulse and a sticky done flag are raised. The analog comparator, DAC and sample-hold sit outside the block and are driven by the trial code and by the init and hold controls.

Top module: `sar_seq_core`

## Requirements
- R1: While `rst_ni` is low, and after it rises, `trial_o`, `result_o`, `init_o`, `hold_o`, `busy_o`, `eoc_o` and `done_o` are all zero.
- R2: A clock edge that samples `cs_ni`=0 and `wr_ni`=0 enters initialization. After that edge `init_o`=1, `busy_o`=1, `trial_o` is all ones, and `done_o`=0.
- R3: With `cs_ni`=1, a low `wr_ni` is ignored: `busy_o`, `init_o`, `done_o` and `result_o` do not change.
- R4: After release, `trial_o` stays all ones until a divide-by-4 boundary. The first trial is then the MSB alone (value 512).
- R5: Each bit decision keeps the tested bit when `cmp_i`=1 (input at or above the trial) and clears it otherwise, then sets the next lower bit. `trial_o` changes only on the last clock of a four-clock slot. With an ideal comparator, `result_o` equals the input value.
- R6: `done_o` rises at the 43rd to 46th rising edge after the edge that first samples the strobe released.
- R7: The phase counter is never reset by the strobe. Two releases a multiple of 4 clocks apart give the same latency. A release one clock later gives a latency shorter by one, or 46 when the earlier latency was 43.
- R8: `eoc_o` is a single-cycle pulse that rises together with `done_o`. `done_o` and `result_o` then hold until the next start, and `result_o` changes only with `eoc_o`.
- R9: `hold_o` is 0 during initialization. It is 1 by the last clock of the first bit slot and stays 1 through completion until the next start.
- R10: A start during a conversion aborts it and re-enters initialization. The following conversion completes with a correct result and normal latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| wr_ni | input | 1 | Active-low write strobe that starts a conversion |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the trial level |
| trial_o | output | 10 | Trial code to the DAC |
| init_o | output | 1 | Initialization phase: auto-zero and sample the positive input |
| hold_o | output | 1 | Positive input held, negative input sampled, DAC on comparator |
| busy_o | output | 1 | Conversion sequence in progress |
| eoc_o | output | 1 | One-cycle pulse when the result is loaded |
| done_o | output | 1 | Result valid; cleared by the next start |
| result_o | output | 10 | Converted code |

## Verification
The assertions assume that `cmp_i` is settled with respect to the current `trial_o` before the last clock of each slot, and that the strobe is a synchronous level sampled once per edge. The bench models the comparator as a combinational compare between a stored input value and `trial_o`. It drives the strobe and chip select only on falling edges. Every strobe is held for at least one full clock, and releases are placed at chosen phase offsets from a global cycle count.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_SYNC,
    ST_TEST,
    ST_LATCH
  } seq_state_e;
endpackage

// File: rtl/sar_phase_div.sv
module sar_phase_div #(
  parameter int SLOT_CLKS = 4,
  localparam int PH_W = $clog2(SLOT_CLKS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] ph_o,
  output logic            last_o
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_CLKS - 1);

  logic [PH_W-1:0] ph_q;

  // free-running; no start input by design
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ph_q <= '0;
    else if (ph_q == PH_LAST)  ph_q <= '0;
    else                       ph_q <= ph_q + 1'b1;
  end

  assign ph_o   = ph_q;
  assign last_o = (ph_q == PH_LAST);
endmodule

// File: rtl/sar_word.sv
module sar_word #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              ld_msb_i,
  input  logic              decide_i,
  input  logic              cmp_i,
  input  logic              latch_i,
  output logic [DATA_W-1:0] trial_o,
  output logic [DATA_W-1:0] result_o,
  output logic              last_bit_o
);
  localparam logic [DATA_W-1:0] MSB_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] trial_q, msk_q, res_q;
  logic [DATA_W-1:0] keep_bit;

  assign keep_bit = cmp_i ? msk_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trial_q <= '0;
      msk_q   <= '0;
    end else if (init_i) begin
      trial_q <= '1;
      msk_q   <= '0;
    end else if (ld_msb_i) begin
      trial_q <= MSB_ONLY;
      msk_q   <= MSB_ONLY;
    end else if (decide_i) begin
      trial_q <= (trial_q & ~msk_q) | keep_bit | (msk_q >> 1);
      msk_q   <= msk_q >> 1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      res_q <= '0;
    else if (latch_i) res_q <= trial_q;
  end

  assign trial_o    = trial_q;
  assign result_o   = res_q;
  assign last_bit_o = msk_q[0];

  AST_DECIDE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decide_i |-> $onehot0(msk_q) && (msk_q != '0)); // R5
endmodule

// File: rtl/sar_ctrl_fsm.sv
module sar_ctrl_fsm
  import sar_seq_pkg::*;
#(
  parameter int SLOT_CLKS = 4,
  parameter int LATCH_DLY = 2,
  parameter int HOLD_PH   = 2,
  localparam int PH_W = $clog2(SLOT_CLKS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            strobe_i,
  input  logic            last_slot_i,
  input  logic [PH_W-1:0] ph_i,
  input  logic            last_bit_i,
  output seq_state_e      state_o,
  output logic            ld_msb_o,
  output logic            decide_o,
  output logic            latch_o,
  output logic            hold_o,
  output logic            done_o,
  output logic            eoc_o
);
  localparam int LCW = (LATCH_DLY > 1) ? $clog2(LATCH_DLY) : 1;
  localparam logic [LCW-1:0] LAST_CNT = LCW'(LATCH_DLY - 1);
  localparam logic [PH_W-1:0] HOLD_AT = PH_W'(HOLD_PH);

  seq_state_e     state_q, state_d;
  logic [LCW-1:0] cnt_q, cnt_d;
  logic           hold_q, done_q, eoc_q;
  logic           ld_msb, decide, latch;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ld_msb  = 1'b0;
    decide  = 1'b0;
    latch   = 1'b0;
    if (strobe_i) begin
      state_d = ST_INIT;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_IDLE;
        ST_INIT: state_d = ST_SYNC;
        ST_SYNC: if (last_slot_i) begin
          state_d = ST_TEST;
          ld_msb  = 1'b1;
        end
        ST_TEST: if (last_slot_i) begin
          decide = 1'b1;
          if (last_bit_i) begin
            state_d = ST_LATCH;
            cnt_d   = '0;
          end
        end
        ST_LATCH: if (cnt_q == LAST_CNT) begin
          latch   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      done_q <= 1'b0;
      eoc_q  <= 1'b0;
    end else begin
      eoc_q <= latch;
      if (strobe_i) begin
        hold_q <= 1'b0;
        done_q <= 1'b0;
      end else begin
        if (state_q == ST_TEST && ph_i == HOLD_AT) hold_q <= 1'b1;
        if (latch) done_q <= 1'b1;
      end
    end
  end

  assign state_o  = state_q;
  assign ld_msb_o = ld_msb;
  assign decide_o = decide;
  assign latch_o  = latch;
  assign hold_o   = hold_q;
  assign done_o   = done_q;
  assign eoc_o    = eoc_q;

  AST_TEST_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SYNC && last_slot_i && !strobe_i) |=> (ph_i == '0)); // R4
  AST_EOC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_q |=> !eoc_q); // R8
  AST_DONE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !strobe_i) |=> done_q); // R8
  AST_HOLD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TEST && last_slot_i) |-> hold_q); // R9
  AST_HOLD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !strobe_i) |=> hold_q); // R9
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> (state_q == ST_INIT) && !done_q && !hold_q); // R10
endmodule

// File: rtl/sar_seq_core.sv
module sar_seq_core
  import sar_seq_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int SLOT_CLKS = 4,
  parameter int LATCH_DLY = 2,
  parameter int HOLD_PH   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic              cmp_i,
  output logic [DATA_W-1:0] trial_o,
  output logic              init_o,
  output logic              hold_o,
  output logic              busy_o,
  output logic              eoc_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int PH_W = $clog2(SLOT_CLKS);

  logic            strobe;
  logic [PH_W-1:0] ph;
  logic            last_slot, last_bit;
  logic            ld_msb, decide, latch;
  seq_state_e      state;

  assign strobe = ~cs_ni & ~wr_ni;

  sar_phase_div #(.SLOT_CLKS(SLOT_CLKS)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ph_o   (ph),
    .last_o (last_slot)
  );

  sar_ctrl_fsm #(
    .SLOT_CLKS (SLOT_CLKS),
    .LATCH_DLY (LATCH_DLY),
    .HOLD_PH   (HOLD_PH)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_i    (strobe),
    .last_slot_i (last_slot),
    .ph_i        (ph),
    .last_bit_i  (last_bit),
    .state_o     (state),
    .ld_msb_o    (ld_msb),
    .decide_o    (decide),
    .latch_o     (latch),
    .hold_o      (hold_o),
    .done_o      (done_o),
    .eoc_o       (eoc_o)
  );

  sar_word #(.DATA_W(DATA_W)) u_word (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (strobe),
    .ld_msb_i   (ld_msb),
    .decide_i   (decide),
    .cmp_i      (cmp_i),
    .latch_i    (latch),
    .trial_o    (trial_o),
    .result_o   (result_o),
    .last_bit_o (last_bit)
  );

  assign init_o = (state == ST_INIT);
  assign busy_o = (state != ST_IDLE);

  AST_INIT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o |-> (trial_o == '1)); // R2
  AST_SYNC_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SYNC) |-> (trial_o == '1)); // R4
  AST_TRIAL_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_TEST && !last_slot && !strobe) |=> $stable(trial_o)); // R5
  AST_RESULT_EOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> eoc_o); // R8
  AST_EOC_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> done_o); // R8
endmodule

// File: tb/sar_seq_core_test.sv
module sar_seq_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 10;
  localparam int NV = 8;
  localparam int VIN_TAB [NV] = '{0, 1023, 512, 511, 341, 682, 1, 1022};
  localparam int GAP_TAB [NV] = '{0, 1, 2, 3, 5, 6, 7, 9};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic wr_n = 1'b1;
  logic [W-1:0] vin = '0;
  logic cmp;
  logic [W-1:0] trial, result;
  logic init, hold, busy, eoc, done;

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  int last_rel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // ideal comparator model
  assign cmp = (vin >= trial);

  sar_seq_core uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .cs_ni    (cs_n),
    .wr_ni    (wr_n),
    .cmp_i    (cmp),
    .trial_o  (trial),
    .init_o   (init),
    .hold_o   (hold),
    .busy_o   (busy),
    .eoc_o    (eoc),
    .done_o   (done),
    .result_o (result)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_conv(input int v, input int align_ref, input int align_mod,
                          output int lat);
    int rel;
    bit seen;
    vin = v[W-1:0];
    cs_n = 1'b0;
    wr_n = 1'b0;
    @(negedge clk);
    check(init == 1'b1, "R2 init_o", int'(init), 1);
    check(trial == '1, "R2 trial full scale", int'(trial), 1023);
    check(busy && !done, "R2 busy/done", int'({busy, done}), 2);
    check(hold == 1'b0, "R9 hold low in init", int'(hold), 0);
    if (align_ref >= 0)
      while (((cyc - align_ref) % 4) != align_mod) @(negedge clk);
    rel = cyc;
    cs_n = 1'b1;
    wr_n = 1'b1;
    seen = 1'b0;
    lat = -1;
    for (int n = 0; n < 80; n++) begin
      @(negedge clk);
      if (!seen && !init && trial != '1) begin
        seen = 1'b1;
        check(trial == 10'h200, "R4 first trial", int'(trial), 512);
      end
      if (done) begin
        lat = cyc - rel - 1;
        break;
      end
    end
    last_rel = rel;
    check(lat >= 43 && lat <= 46, "R6 latency", lat, 43);
    check(result == v[W-1:0], "R5 result", int'(result), v);
    check(eoc == 1'b1, "R8 eoc with done", int'(eoc), 1);
    check(hold == 1'b1, "R9 hold at done", int'(hold), 1);
    @(negedge clk);
    check(eoc == 1'b0 && done == 1'b1, "R8 eoc pulse/done sticky",
          int'({eoc, done}), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lat, l1, l2, l3, r;
    logic [W-1:0] keep;
    // R1 reset state
    repeat (3) @(negedge clk);
    check({trial, result, init, hold, busy, eoc, done} == '0, "R1 in reset",
          int'(trial), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({trial, result, init, hold, busy, eoc, done} == '0, "R1 after reset",
          int'(result), 0);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      repeat (GAP_TAB[i]) @(negedge clk);
      run_conv(VIN_TAB[i], -1, 0, lat);
    end

    // R3: write with chip select high ignored
    keep = result;
    wr_n = 1'b0;
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !init && done && result == keep, "R3 deselected write",
          int'(result), int'(keep));
    wr_n = 1'b1;
    @(negedge clk);

    // R7: phase counter not tied to the strobe
    run_conv(300, -1, 0, l1);
    r = last_rel;
    run_conv(300, r, 0, l2);
    check(l2 == l1, "R7 same phase latency", l2, l1);
    r = last_rel;
    run_conv(300, r, 1, l3);
    check(l3 == ((l2 == 43) ? 46 : l2 - 1), "R7 shifted phase latency", l3,
          (l2 == 43) ? 46 : l2 - 1);

    // R10: restart mid-conversion
    vin = 10'd100;
    cs_n = 1'b0;
    wr_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1;
    wr_n = 1'b1;
    repeat (20) @(negedge clk);
    check(busy && !init && !done, "R10 mid conversion", int'({busy, init, done}), 4);
    check(hold == 1'b1, "R9 hold mid conversion", int'(hold), 1);
    run_conv(777, -1, 0, lat);
    check(result == 10'd777 && lat >= 43 && lat <= 46, "R10 restarted result",
          int'(result), 777);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule